// File: doc/BRIEF.md
# Descriptor Ring Completion Engine

This block runs one descriptor ring of a host DMA channel, either the transmit or the receive flavour, chosen by the `IS_RX` parameter. Software sets a ring base in a local descriptor RAM, a descriptor count and a producer (head) index. The engine keeps its own consumer (tail) index and processes descriptors from tail up to head. For each descriptor it reads 128 bits from the RAM, offers the transfer to a valid/ready payload stub, and then writes the same slot back with the completed flag set. The tail then advances, wrapping to zero at the count.

A transmit ring offers the descriptor's length and frame markers to the payload side. A receive ring offers its frame-size capacity and records the length and markers that the payload side returns. A descriptor that does not carry the posted flag halts the engine. It stays halted until software rewrites the head index or clears the enable bit. A one-cycle completion event fires whenever a finished descriptor requested it.

The controller has six states. `ST_IDLE` waits for work. `ST_FETCH` issues the RAM read. `ST_WAIT` receives the read data. `ST_XFER` offers the payload transfer. `ST_WB` writes the descriptor back and advances the tail. `ST_HALT` parks on an unposted descriptor. The transitions are:
- idle to fetch when work is pending;
- fetch to wait, always;
- wait to transfer when the posted flag is set, otherwise wait to halt;
- transfer to writeback on ready;
- writeback to idle, always;
- halt to idle on a head change or when the enable bit clears.

Top module: `dring_engine`

## Requirements
- R1: After reset the tail is 0 and `mem_req`, `xfer_valid` and `evt_done` are low.
- R2: No RAM access starts while option bit 31 (enable) is clear, while the count is 0, or while the tail equals the head.
- R3: Descriptor slot i lives at RAM word `cfg_base + i`. Its layout is: bits 63:0 buffer address, 75:64 length, 79:76 end-of-frame code, 83:80 start-of-frame code, 95:84 flags, 127:96 timestamp. The engine reads and writes back the slot at `cfg_base + tail`.
- R4: Flag bit 2 (word bit 86) marks a descriptor as posted. When it is clear, the engine neither offers a transfer, nor writes back, nor advances the tail. It stays put until `cfg_head` changes or enable clears.
- R5: On a transmit ring, `xfer_valid` offers the descriptor length and the masked markers. `xfer_valid` stays high and the tail stays still while `xfer_ready` is low.
- R6: On a receive ring, the offered length is the capacity, min(`cfg_max_frame`, 0x100). The written-back length is min(`xfer_len_i`, capacity). The written-back markers are the masked `xfer_sof_i`/`xfer_eof_i`.
- R7: The writeback sets flag bit 1 (word bit 85) and writes a zero timestamp. It keeps the address and the other flags. On transmit it also keeps the length and markers unchanged.
- R8: Each writeback advances the tail by one. The tail becomes 0 when the next value would reach `cfg_count`.
- R9: `evt_done` is high for exactly the writeback cycle when flag bit 3 (word bit 87) is set, and low otherwise.
- R10: With option bit 30 (raw) clear, a marker code c is passed only if mask bit c is set; otherwise it becomes 0. The start-of-frame mask is `cfg_frame_mask[31:16]` and the end-of-frame mask is `cfg_frame_mask[15:0]`. With raw set, codes pass unchanged.
- R11: Enable is sampled only between descriptors. A descriptor already fetched completes its writeback even if enable clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_opts | input | 32 | Ring options: bit 31 enable, bit 30 raw |
| cfg_frame_mask | input | 32 | Start-of-frame mask [31:16], end-of-frame mask [15:0] |
| cfg_base | input | RAM_AW | RAM word of descriptor slot 0 |
| cfg_count | input | IDX_W+1 | Number of descriptors in the ring |
| cfg_head | input | IDX_W | Producer index (first unposted slot) |
| cfg_max_frame | input | 12 | Receive frame-size limit |
| tail | output | IDX_W | Consumer index |
| mem_req | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write (with mem_req) |
| mem_addr | output | RAM_AW | RAM word address |
| mem_wdata | output | 128 | RAM write data |
| mem_rdata | input | 128 | RAM read data, valid one cycle after a read strobe |
| xfer_valid | output | 1 | Payload transfer offered |
| xfer_ready | input | 1 | Payload side accepts |
| xfer_len_o | output | 12 | Transmit length or receive capacity |
| xfer_sof_o | output | 4 | Transmit start-of-frame code (0 on receive) |
| xfer_eof_o | output | 4 | Transmit end-of-frame code (0 on receive) |
| xfer_len_i | input | 12 | Receive length from the payload side |
| xfer_sof_i | input | 4 | Receive start-of-frame code |
| xfer_eof_i | input | 4 | Receive end-of-frame code |
| evt_done | output | 1 | One-cycle completion event |

## Verification
The hardest situation to reach is the halt on an unposted descriptor followed by a clean resume. The bench posts a slot with the posted flag clear and moves the head past it. It confirms that the tail freezes and that no writeback appears. It then repairs the slot and the one after it through the RAM, and rewrites the head to a different value so that the engine refetches. Clearing enable while a transfer is held back by a low ready is reached the same way, by holding ready low until the offer is seen.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int DESC_W  = 128;
    localparam int FL_ISO  = 0;
    localparam int FL_DONE = 1;
    localparam int FL_POST = 2;
    localparam int FL_IRQ  = 3;
    localparam int OPT_EN  = 31;
    localparam int OPT_RAW = 30;
    localparam logic [11:0] FRAME_CAP = 12'h100;

    typedef struct packed {
        logic [31:0] stamp;
        logic [11:0] flags;
        logic [3:0]  sof;
        logic [3:0]  eof;
        logic [11:0] len;
        logic [63:0] buf_addr;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_XFER,
        ST_WB,
        ST_HALT
    } eng_state_t;

endpackage

// File: rtl/dring_tail_ctr.sv
module dring_tail_ctr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W:0]   count,
    output logic [IDX_W-1:0] tail
);
    localparam int CNT_W = IDX_W + 1;

    logic [CNT_W-1:0] next_wide;

    assign next_wide = {1'b0, tail} + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (adv) begin
            if (next_wide >= count) begin
                tail <= '0;
            end else begin
                tail <= next_wide[IDX_W-1:0];
            end
        end
    end

    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tail != $past(tail)) |-> (tail == '0 || tail == $past(tail) + 1'b1)); // R8

endmodule

// File: rtl/dring_code_mask.sv
module dring_code_mask (
    input  logic        raw,
    input  logic [15:0] mask,
    input  logic [3:0]  code_in,
    output logic [3:0]  code_out
);
    always_comb begin
        if (raw || mask[code_in]) begin
            code_out = code_in;
        end else begin
            code_out = 4'h0;
        end
    end
endmodule

// File: rtl/dring_wb_build.sv
module dring_wb_build
    import dring_pkg::*;
#(
    parameter bit IS_RX = 1'b0
) (
    input  desc_t       rd,
    input  logic [11:0] rx_len,
    input  logic [11:0] cap,
    input  logic [3:0]  rx_sof,
    input  logic [3:0]  rx_eof,
    output desc_t       wb
);
    generate
        if (IS_RX) begin : g_rx
            always_comb begin
                wb = rd;
                wb.stamp = '0;
                wb.flags[FL_DONE] = 1'b1;
                wb.len = (rx_len > cap) ? cap : rx_len;
                wb.sof = rx_sof;
                wb.eof = rx_eof;
            end
        end else begin : g_tx
            logic unused_rx;
            assign unused_rx = ^{rx_len, cap, rx_sof, rx_eof};
            always_comb begin
                wb = rd;
                wb.stamp = '0;
                wb.flags[FL_DONE] = 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/dring_engine.sv
module dring_engine
    import dring_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int RAM_AW = 6,
    parameter bit IS_RX  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_opts,
    input  logic [31:0]       cfg_frame_mask,
    input  logic [RAM_AW-1:0] cfg_base,
    input  logic [IDX_W:0]    cfg_count,
    input  logic [IDX_W-1:0]  cfg_head,
    input  logic [11:0]       cfg_max_frame,
    output logic [IDX_W-1:0]  tail,
    output logic              mem_req,
    output logic              mem_we,
    output logic [RAM_AW-1:0] mem_addr,
    output logic [127:0]      mem_wdata,
    input  logic [127:0]      mem_rdata,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [11:0]       xfer_len_o,
    output logic [3:0]        xfer_sof_o,
    output logic [3:0]        xfer_eof_o,
    input  logic [11:0]       xfer_len_i,
    input  logic [3:0]        xfer_sof_i,
    input  logic [3:0]        xfer_eof_i,
    output logic              evt_done
);
    localparam int LANES = 2;

    eng_state_t       state, nxt;
    desc_t            desc_q;
    desc_t            rd_view;
    desc_t            wb_view;
    logic [IDX_W-1:0] halt_head;
    logic [11:0]      rx_len_q;
    logic [3:0]       rx_sof_q;
    logic [3:0]       rx_eof_q;
    logic [11:0]      cap;
    logic             enabled;
    logic             raw;
    logic             work;
    logic             advance;

    logic [3:0]  code_in   [LANES];
    logic [3:0]  code_out  [LANES];
    logic [15:0] lane_mask [LANES];

    assign rd_view = desc_t'(mem_rdata);
    assign enabled = cfg_opts[OPT_EN];
    assign raw     = cfg_opts[OPT_RAW];
    assign cap     = (cfg_max_frame > FRAME_CAP) ? FRAME_CAP : cfg_max_frame;
    assign work    = enabled && (cfg_count != '0) && (tail != cfg_head);

    // lane 0: end-of-frame, lane 1: start-of-frame
    assign lane_mask[0] = cfg_frame_mask[15:0];
    assign lane_mask[1] = cfg_frame_mask[31:16];

    generate
        if (IS_RX) begin : g_src_rx
            assign code_in[0] = xfer_eof_i;
            assign code_in[1] = xfer_sof_i;
        end else begin : g_src_tx
            assign code_in[0] = desc_q.eof;
            assign code_in[1] = desc_q.sof;
        end
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            dring_code_mask u_mask (
                .raw      (raw),
                .mask     (lane_mask[g]),
                .code_in  (code_in[g]),
                .code_out (code_out[g])
            );
        end
    endgenerate

    dring_tail_ctr #(.IDX_W(IDX_W)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (advance),
        .count (cfg_count),
        .tail  (tail)
    );

    dring_wb_build #(.IS_RX(IS_RX)) u_build (
        .rd     (desc_q),
        .rx_len (rx_len_q),
        .cap    (cap),
        .rx_sof (rx_sof_q),
        .rx_eof (rx_eof_q),
        .wb     (wb_view)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (work) nxt = ST_FETCH;
            ST_FETCH: nxt = ST_WAIT;
            ST_WAIT:  nxt = rd_view.flags[FL_POST] ? ST_XFER : ST_HALT;
            ST_XFER:  if (xfer_ready) nxt = ST_WB;
            ST_WB:    nxt = ST_IDLE;
            ST_HALT:  if ((cfg_head != halt_head) || !enabled) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q    <= '0;
            halt_head <= '0;
            rx_len_q  <= '0;
            rx_sof_q  <= '0;
            rx_eof_q  <= '0;
        end else begin
            if (state == ST_WAIT) begin
                desc_q    <= rd_view;
                halt_head <= cfg_head;
            end
            if (state == ST_XFER && xfer_ready) begin
                rx_len_q <= xfer_len_i;
                rx_sof_q <= code_out[1];
                rx_eof_q <= code_out[0];
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        xfer_valid = 1'b0;
        evt_done   = 1'b0;
        advance    = 1'b0;
        unique case (state)
            ST_FETCH: mem_req = 1'b1;
            ST_XFER:  xfer_valid = 1'b1;
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                advance  = 1'b1;
                evt_done = desc_q.flags[FL_IRQ];
            end
            default: ;
        endcase
    end

    assign mem_addr  = cfg_base + RAM_AW'(tail);
    assign mem_wdata = wb_view;

    generate
        if (IS_RX) begin : g_out_rx
            assign xfer_len_o = cap;
            assign xfer_sof_o = 4'h0;
            assign xfer_eof_o = 4'h0;

            AST_RX_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                mem_we |-> (mem_wdata[75:64] <= FRAME_CAP)); // R6
        end else begin : g_out_tx
            assign xfer_len_o = desc_q.len;
            assign xfer_sof_o = code_out[1];
            assign xfer_eof_o = code_out[0];
        end
    endgenerate

    AST_WRITE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(xfer_valid && xfer_ready)); // R7

    AST_DONE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[85] && mem_wdata[127:96] == 32'h0)); // R7

    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done); // R9

    AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(tail))); // R5

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> $stable(tail)); // R4

endmodule

// File: tb/sim_dring_engine.sv
module sim_dring_engine;

    typedef struct packed {
        logic         unit;
        logic [5:0]   addr;
        logic [127:0] data;
        logic         evt;
    } wb_item_t;

    typedef struct packed {
        logic        unit;
        logic [11:0] len;
        logic [3:0]  sof;
        logic [3:0]  eof;
    } off_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0]  opts = 32'h0;
    logic [31:0]  fmask = {16'h0006, 16'h0030};
    logic [5:0]   base = 6'd8;
    logic [4:0]   count = 5'd4;
    logic [3:0]   head_t = 4'd0, head_r = 4'd0;
    logic [11:0]  max_frame = 12'h100;
    logic         tx_ready = 1'b1, rx_ready = 1'b1;
    logic [11:0]  rx_len_i = 12'h0;
    logic [3:0]   rx_sof_i = 4'h0, rx_eof_i = 4'h0;

    logic [3:0]   t_tail, r_tail;
    logic         t_req, t_we, r_req, r_we;
    logic [5:0]   t_addr, r_addr;
    logic [127:0] t_wdata, r_wdata, t_rdata, r_rdata;
    logic         t_xv, r_xv, t_evt, r_evt;
    logic [11:0]  t_len_o, r_len_o;
    logic [3:0]   t_sof_o, t_eof_o, r_sof_o, r_eof_o;

    logic         hw_en = 1'b0, hw_unit = 1'b0;
    logic [5:0]   hw_addr = '0;
    logic [127:0] hw_data = '0;
    logic [127:0] ram_t [64];
    logic [127:0] ram_r [64];

    int checks = 0;
    int fails = 0;
    wb_item_t  wq[$];
    off_item_t oq[$];

    dring_engine #(.IDX_W(4), .RAM_AW(6), .IS_RX(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_opts(opts), .cfg_frame_mask(fmask),
        .cfg_base(base), .cfg_count(count), .cfg_head(head_t), .cfg_max_frame(max_frame),
        .tail(t_tail), .mem_req(t_req), .mem_we(t_we), .mem_addr(t_addr),
        .mem_wdata(t_wdata), .mem_rdata(t_rdata), .xfer_valid(t_xv), .xfer_ready(tx_ready),
        .xfer_len_o(t_len_o), .xfer_sof_o(t_sof_o), .xfer_eof_o(t_eof_o),
        .xfer_len_i(12'h0), .xfer_sof_i(4'h0), .xfer_eof_i(4'h0), .evt_done(t_evt));

    dring_engine #(.IDX_W(4), .RAM_AW(6), .IS_RX(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_opts(opts), .cfg_frame_mask(fmask),
        .cfg_base(base), .cfg_count(count), .cfg_head(head_r), .cfg_max_frame(max_frame),
        .tail(r_tail), .mem_req(r_req), .mem_we(r_we), .mem_addr(r_addr),
        .mem_wdata(r_wdata), .mem_rdata(r_rdata), .xfer_valid(r_xv), .xfer_ready(rx_ready),
        .xfer_len_o(r_len_o), .xfer_sof_o(r_sof_o), .xfer_eof_o(r_eof_o),
        .xfer_len_i(rx_len_i), .xfer_sof_i(rx_sof_i), .xfer_eof_i(rx_eof_i), .evt_done(r_evt));

    // descriptor RAM models, one read cycle of latency
    always @(posedge clk) begin
        if (hw_en) begin
            if (hw_unit) ram_r[hw_addr] <= hw_data;
            else         ram_t[hw_addr] <= hw_data;
        end
        if (t_req) begin
            if (t_we) ram_t[t_addr] <= t_wdata;
            else      t_rdata <= ram_t[t_addr];
        end
        if (r_req) begin
            if (r_we) ram_r[r_addr] <= r_wdata;
            else      r_rdata <= ram_r[r_addr];
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [3:0] mk(input bit raw, input logic [15:0] m, input logic [3:0] c);
        return (raw || m[c]) ? c : 4'h0;
    endfunction

    function automatic logic [11:0] capv();
        return (max_frame > 12'h100) ? 12'h100 : max_frame;
    endfunction

    // driver: writes a descriptor and pushes the expected results
    task automatic post(input bit u, input int idx, input logic [11:0] len, input logic [3:0] sof,
                        input logic [3:0] eof, input bit irq, input bit posted);
        logic [127:0] d;
        wb_item_t     w;
        off_item_t    o;
        bit           raw;
        raw = opts[30];
        d = {32'hA5A50000 | 32'(idx), 8'h00, irq, posted, 1'b0, 1'b0, sof, eof, len,
             64'h0000_1000_0000_0000 + 64'(idx)};
        @(negedge clk);
        hw_unit = u; hw_en = 1'b1; hw_addr = base + 6'(idx); hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
        if (posted) begin
            w.unit = u; w.addr = base + 6'(idx); w.evt = irq;
            w.data = d;
            w.data[127:96] = 32'h0;
            w.data[85] = 1'b1;
            o.unit = u;
            if (u) begin
                w.data[75:64] = (rx_len_i > capv()) ? capv() : rx_len_i;
                w.data[83:80] = mk(raw, fmask[31:16], rx_sof_i);
                w.data[79:76] = mk(raw, fmask[15:0], rx_eof_i);
                o.len = capv(); o.sof = 4'h0; o.eof = 4'h0;
            end else begin
                o.len = len; o.sof = mk(raw, fmask[31:16], sof); o.eof = mk(raw, fmask[15:0], eof);
            end
            wq.push_back(w);
            oq.push_back(o);
        end
    endtask

    task automatic sb_write(input bit u, input logic [5:0] a, input logic [127:0] d, input bit e);
        wb_item_t w;
        if (wq.size() == 0) begin
            chk(1'b0, "R7 unexpected writeback", d, 128'h0);
        end else begin
            w = wq.pop_front();
            chk(w.unit == u && w.addr == a, "R3 writeback slot", {u, a}, {w.unit, w.addr});
            chk(w.data == d, u ? "R6 receive writeback" : "R7 writeback word", d, w.data);
            chk(w.evt == e, "R9 event", 128'(e), 128'(w.evt));
        end
    endtask

    task automatic sb_offer(input bit u, input logic [11:0] l, input logic [3:0] s, input logic [3:0] f);
        off_item_t o;
        if (oq.size() == 0) begin
            chk(1'b0, "R5 unexpected offer", {u, l, s, f}, 128'h0);
        end else begin
            o = oq.pop_front();
            chk(o == {u, l, s, f}, u ? "R6 capacity offer" : "R10 transmit offer", {u, l, s, f}, o);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (t_req && t_we) sb_write(1'b0, t_addr, t_wdata, t_evt);
            if (r_req && r_we) sb_write(1'b1, r_addr, r_wdata, r_evt);
            if (t_evt && !t_we) chk(1'b0, "R9 stray event tx", 128'h1, 128'h0);
            if (r_evt && !r_we) chk(1'b0, "R9 stray event rx", 128'h1, 128'h0);
            if (t_xv && tx_ready) sb_offer(1'b0, t_len_o, t_sof_o, t_eof_o);
            if (r_xv && rx_ready) sb_offer(1'b1, r_len_o, r_sof_o, r_eof_o);
        end
    end

    task automatic wait_tail(input bit u, input logic [3:0] v, input string rq);
        int n = 0;
        while (((u ? r_tail : t_tail) != v) && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk((u ? r_tail : t_tail) == v, rq, 128'(u ? r_tail : t_tail), 128'(v));
        repeat (2) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string rq);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (t_req || r_req) hits++;
        end
        chk(hits == 0, rq, 128'(hits), 128'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(t_tail == 0 && r_tail == 0, "R1 tails", {t_tail, r_tail}, 128'h0);
        chk(!t_req && !r_req && !t_xv && !r_xv && !t_evt && !r_evt, "R1 outputs",
            {t_req, r_req, t_xv, r_xv, t_evt, r_evt}, 128'h0);

        // R2: pending work but disabled, then count zero
        post(1'b0, 0, 12'h040, 4'd1, 4'd4, 1'b1, 1'b1);
        head_t = 4'd1;
        quiet(20, "R2 disabled");
        opts = 32'h8000_0000;
        count = 5'd0;
        quiet(20, "R2 zero count");
        count = 5'd4;
        wait_tail(1'b0, 4'd1, "R8 first advance");
        quiet(10, "R2 tail equals head");

        // R3 R7 R9 R10: several descriptors, wrap through the end
        post(1'b0, 1, 12'h123, 4'd2, 4'd5, 1'b1, 1'b1);
        post(1'b0, 2, 12'hFFF, 4'd7, 4'd9, 1'b0, 1'b1);
        post(1'b0, 3, 12'h001, 4'd1, 4'd4, 1'b1, 1'b1);
        head_t = 4'd0;
        wait_tail(1'b0, 4'd0, "R8 wrap to zero");

        // R5 backpressure
        tx_ready = 1'b0;
        post(1'b0, 0, 12'h0AA, 4'd2, 4'd4, 1'b0, 1'b1);
        head_t = 4'd1;
        repeat (12) @(negedge clk);
        chk(t_xv == 1'b1 && t_tail == 4'd0, "R5 held offer", {t_xv, t_tail}, {1'b1, 4'd0});
        tx_ready = 1'b1;
        wait_tail(1'b0, 4'd1, "R5 release");

        // R10 raw mode
        opts = 32'hC000_0000;
        post(1'b0, 1, 12'h077, 4'd7, 4'd9, 1'b1, 1'b1);
        head_t = 4'd2;
        wait_tail(1'b0, 4'd2, "R10 raw advance");
        opts = 32'h8000_0000;

        // R4 unposted halt and resume
        post(1'b0, 2, 12'h010, 4'd1, 4'd5, 1'b1, 1'b0);
        head_t = 4'd3;
        repeat (20) @(negedge clk);
        chk(t_tail == 4'd2 && !t_xv, "R4 halted", {t_xv, t_tail}, {1'b0, 4'd2});
        post(1'b0, 2, 12'h010, 4'd1, 4'd5, 1'b1, 1'b1);
        post(1'b0, 3, 12'h020, 4'd2, 4'd4, 1'b0, 1'b1);
        head_t = 4'd0;
        wait_tail(1'b0, 4'd0, "R4 resumed");

        // R11 enable cleared mid-descriptor
        tx_ready = 1'b0;
        post(1'b0, 0, 12'h055, 4'd2, 4'd5, 1'b1, 1'b1);
        head_t = 4'd1;
        for (int n = 0; n < 100 && !t_xv; n++) @(negedge clk);
        opts = 32'h0;
        tx_ready = 1'b1;
        wait_tail(1'b0, 4'd1, "R11 finishes started descriptor");
        post(1'b0, 1, 12'h066, 4'd1, 4'd4, 1'b0, 1'b1);
        head_t = 4'd2;
        quiet(20, "R11 no new fetch");
        opts = 32'h8000_0000;
        wait_tail(1'b0, 4'd2, "R2 re-enabled");

        // R6 receive ring
        max_frame = 12'h300;
        rx_len_i = 12'h1A0; rx_sof_i = 4'd1; rx_eof_i = 4'd4;
        post(1'b1, 0, 12'h555, 4'd3, 4'd3, 1'b1, 1'b1);
        head_r = 4'd1;
        wait_tail(1'b1, 4'd1, "R6 rx clamp");
        max_frame = 12'h040;
        rx_len_i = 12'h080; rx_sof_i = 4'd3; rx_eof_i = 4'd6;
        post(1'b1, 1, 12'h000, 4'd0, 4'd0, 1'b0, 1'b1);
        head_r = 4'd2;
        wait_tail(1'b1, 4'd2, "R6 rx small limit");
        max_frame = 12'h100;
        rx_len_i = 12'h0FF; rx_sof_i = 4'd2; rx_eof_i = 4'd5;
        post(1'b1, 2, 12'h000, 4'd0, 4'd0, 1'b1, 1'b1);
        head_r = 4'd3;
        wait_tail(1'b1, 4'd3, "R6 rx under limit");

        chk(wq.size() == 0, "R7 all writebacks seen", 128'(wq.size()), 128'h0);
        chk(oq.size() == 0, "R5 all offers seen", 128'(oq.size()), 128'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule